// File: doc/BRIEF.md
# Serial Audio Side-Channel Receiver

This block takes a serial audio stream in which both the bit clock and the frame clock come from outside. It splits the stream into 32-bit channel subframes. Each subframe carries a 24-bit audio sample and an 8-bit side-channel byte. The byte's position inside the subframe depends on the serial format. A byte from a left subframe and a byte from the following right subframe together form a 16-bit rate-ratio word. An upstream device that produces ratios sends this word. A chip uses it to lock the phase of several converters to one source.

The deserializer runs on the incoming bit clock. Each completed subframe gives a one-cycle strobe, the sample, the byte and a side flag. A subframe of the wrong length gives a framing-error pulse instead. Each complete ratio word crosses into the core clock domain through a toggle handshake. A 3-bit mode input chooses the output ratio. Mode `100` selects the received word. Any other mode selects a ratio supplied by local logic. The two frame clocks involved need not be related.

Top module: `sidechan_rx`

## Requirements
- R1: After reset, byteValid and framingErr are low. While no ratio word has been received, ratioOut equals localRatio, even when modeSel is `100`.
- R2: fmtSel encodes the format: 0 = left-justified, 1 = I2S, 2 = right-justified, 3 = TDM. In left-justified and right-justified formats, a subframe starts on the first bit where frameClk changes, and a high frameClk marks left. In I2S, frameClk low marks left, and each subframe starts one bit after the frameClk change. byteIsRight is 1 for a right subframe.
- R3: In left-justified, I2S and TDM formats, sideByte is the last 8 bits of the subframe. sampleOut is the first 24 bits, most significant bit first.
- R4: In right-justified format, sideByte is the first 8 bits of the subframe. sampleOut is the last 24 bits.
- R5: byteValid is high for exactly one bit-clock cycle. It rises on the first rising bitClk edge of the following subframe.
- R6: A subframe whose length is not 32 bits produces a one-cycle framingErr pulse and no byteValid. The first subframe edge after reset only sets the alignment and reports nothing.
- R7: In TDM format, a one-bit-wide high pulse on frameClk marks the start of slot 0. Each slot is 32 bits. Only slot 0 (left) and slot 1 (right) produce bytes. Later slots are ignored.
- R8: When modeSel is `100` and a ratio word has arrived, ratioOut equals {left byte, right byte} of the newest intact pair. For any other mode, ratioOut is localRatio registered one core clock cycle later.
- R9: A ratio word forms only from an intact left byte followed directly by an intact right byte. A framing error drops the pending left byte.
- R10: A ratio word crosses into the core domain through a toggle request and acknowledge, each passed through a two-flop synchronizer. A new request starts only after the previous one has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| bitClk | input | 1 | External serial bit clock |
| frameClk | input | 1 | External frame clock (channel select, or TDM frame pulse) |
| serialIn | input | 1 | Serial data, most significant bit first |
| fmtSel | input | 2 | Serial format select |
| modeSel | input | 3 | Ratio source mode; `100` follows the received ratio |
| localRatio | input | 16 | Locally derived ratio (core domain) |
| sampleOut | output | 24 | Audio sample of the last completed subframe |
| sideByte | output | 8 | Side-channel byte of the last completed subframe |
| byteValid | output | 1 | One-bit-clock strobe for sampleOut and sideByte |
| byteIsRight | output | 1 | Side of the strobed subframe (1 = right) |
| framingErr | output | 1 | One-bit-clock pulse for a subframe of the wrong length |
| ratioOut | output | 16 | Selected ratio (core domain) |

## Verification
The assertions check on every cycle that:
- the byte strobe lasts a single cycle and never coincides with a framing error;
- a ratio word is launched only together with a strobed right byte;
- the crossing raises a new request only after the previous one is acknowledged;
- ratioOut tracks localRatio whenever the mode is not `100`.

Only the bench scenarios can show that the correct bits are pulled out of each subframe in each of the four formats. They also show the one-bit I2S offset, the filtering of TDM slots, and that a truncated subframe breaks the pairing, so the ratio output keeps its previous word.

// File: rtl/sidechan_pkg.sv
`timescale 1ns/1ps
package sidechan_pkg;
  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_TDM = 2'd3
  } fmt_e;

  // strobes from the framing control to the datapath, valid on a subframe close
  typedef struct packed {
    logic good;     // intact 32-bit subframe inside the channel pair
    logic isRight;  // side of the subframe that just closed
    logic err;      // subframe closed with the wrong bit count
  } strobe_t;

  localparam logic [2:0] MODE_FOLLOW = 3'b100;
endpackage

// File: rtl/sidechan_ctrl.sv
`timescale 1ns/1ps
module sidechan_ctrl
  import sidechan_pkg::*;
#(
  parameter int SUB_BITS = 32
) (
  input  logic       bitClk,
  input  logic       rstN,
  input  logic       frameClk,
  input  logic [1:0] fmtSel,
  output strobe_t    strb
);
  localparam int CNT_W = $clog2(SUB_BITS) + 2;

  fmt_e             fmt;
  logic             lrQ1, lrQ2, synced, curLeft;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0]       slot;
  logic             isTdm, curAl, prevAl, framePulse, fullCnt, boundary, inPair;

  always_comb begin
    fmt        = fmt_e'(fmtSel);
    isTdm      = (fmt == FMT_TDM);
    // I2S: channel select leads the data by one bit, so look one sample back
    curAl      = (fmt == FMT_I2S) ? ~lrQ1 : frameClk;
    prevAl     = (fmt == FMT_I2S) ? ~lrQ2 : lrQ1;
    framePulse = frameClk & ~lrQ1;
    fullCnt    = (bitCnt == CNT_W'(SUB_BITS));
    boundary   = isTdm ? (framePulse | fullCnt) : (curAl != prevAl);
    inPair     = !isTdm || !slot[1];
    strb.good    = boundary & synced & fullCnt & inPair;
    strb.err     = boundary & synced & ~fullCnt;
    strb.isRight = isTdm ? (slot == 2'd1) : ~curLeft;
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      lrQ1    <= 1'b0;
      lrQ2    <= 1'b0;
      synced  <= 1'b0;
      curLeft <= 1'b0;
      bitCnt  <= '0;
      slot    <= '0;
    end else begin
      lrQ1 <= frameClk;
      lrQ2 <= lrQ1;
      if (boundary) begin
        bitCnt  <= CNT_W'(1);
        curLeft <= curAl;
        if (!isTdm || framePulse) synced <= 1'b1;
        if (framePulse)           slot   <= '0;
        else if (slot != 2'd3)    slot   <= slot + 2'd1;
      end else if (bitCnt != '1) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sidechan_dp.sv
`timescale 1ns/1ps
module sidechan_dp
  import sidechan_pkg::*;
#(
  parameter int SUB_BITS = 32,
  parameter int BYTE_W   = 8,
  localparam int SAMPLE_W = SUB_BITS - BYTE_W
) (
  input  logic                bitClk,
  input  logic                rstN,
  input  logic                serialIn,
  input  logic [1:0]          fmtSel,
  input  strobe_t             strb,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic [BYTE_W-1:0]   sideByte,
  output logic                byteValid,
  output logic                byteIsRight,
  output logic                framingErr,
  output logic                launch,
  output logic [2*BYTE_W-1:0] launchWord
);
  logic [SUB_BITS-1:0] sr;
  logic [BYTE_W-1:0]   byteNow, hiByte;
  logic [SAMPLE_W-1:0] sampleNow;
  logic                hiOk;

  // sr holds the full closed subframe on the edge where the next one begins
  always_comb begin
    if (fmt_e'(fmtSel) == FMT_RJ) begin
      byteNow   = sr[SUB_BITS-1 -: BYTE_W];
      sampleNow = sr[SAMPLE_W-1:0];
    end else begin
      byteNow   = sr[BYTE_W-1:0];
      sampleNow = sr[SUB_BITS-1 -: SAMPLE_W];
    end
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      sr          <= '0;
      sampleOut   <= '0;
      sideByte    <= '0;
      byteValid   <= 1'b0;
      byteIsRight <= 1'b0;
      framingErr  <= 1'b0;
      hiByte      <= '0;
      hiOk        <= 1'b0;
      launch      <= 1'b0;
      launchWord  <= '0;
    end else begin
      sr         <= {sr[SUB_BITS-2:0], serialIn};
      byteValid  <= strb.good;
      framingErr <= strb.err;
      launch     <= 1'b0;
      if (strb.good) begin
        sampleOut   <= sampleNow;
        sideByte    <= byteNow;
        byteIsRight <= strb.isRight;
      end
      if (strb.err) begin
        hiOk <= 1'b0;
      end else if (strb.good && !strb.isRight) begin
        hiByte <= byteNow;
        hiOk   <= 1'b1;
      end else if (strb.good) begin
        hiOk       <= 1'b0;
        launch     <= hiOk;
        launchWord <= {hiByte, byteNow};
      end
    end
  end

  // R5: strobe is a single bit-clock pulse
  a_r5_valid_single: assert property (@(posedge bitClk) disable iff (!rstN)
    byteValid |=> !byteValid);
  // R6: a bad subframe never also delivers a byte
  a_r6_err_excludes_valid: assert property (@(posedge bitClk) disable iff (!rstN)
    !(byteValid && framingErr));
  // R9: a ratio word only leaves together with a delivered right byte
  a_r9_launch_on_right: assert property (@(posedge bitClk) disable iff (!rstN)
    launch |-> (byteValid && byteIsRight));
endmodule

// File: rtl/sidechan_xfer.sv
`timescale 1ns/1ps
module sidechan_xfer
  import sidechan_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               bitClk,
  input  logic               clk,
  input  logic               rstN,
  input  logic               launch,
  input  logic [RATIO_W-1:0] launchWord,
  input  logic [2:0]         modeSel,
  input  logic [RATIO_W-1:0] localRatio,
  output logic [RATIO_W-1:0] ratioOut
);
  logic [RATIO_W-1:0] holdWord, rxRatio;
  logic               reqTgl, ackS1, ackS2;
  logic               reqC1, reqC2, reqC3, haveRx;

  // serial side: launch only when the last request has come back
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      reqTgl   <= 1'b0;
      ackS1    <= 1'b0;
      ackS2    <= 1'b0;
    end else begin
      ackS1 <= reqC3;
      ackS2 <= ackS1;
      if (launch && (reqTgl == ackS2)) begin
        holdWord <= launchWord;
        reqTgl   <= ~reqTgl;
      end
    end
  end

  // core side: holdWord is stable while the request toggle is in flight
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqC1    <= 1'b0;
      reqC2    <= 1'b0;
      reqC3    <= 1'b0;
      rxRatio  <= '0;
      haveRx   <= 1'b0;
      ratioOut <= '0;
    end else begin
      reqC1 <= reqTgl;
      reqC2 <= reqC1;
      reqC3 <= reqC2;
      if (reqC2 != reqC3) begin
        rxRatio <= holdWord;
        haveRx  <= 1'b1;
      end
      ratioOut <= (modeSel == MODE_FOLLOW && haveRx) ? rxRatio : localRatio;
    end
  end

  // R10: the request only toggles after the acknowledge has caught up
  a_r10_req_after_ack: assert property (@(posedge bitClk) disable iff (!rstN)
    !$stable(reqTgl) |-> $past(reqTgl == ackS2));
  // R8: outside follow mode the local ratio passes through one cycle later
  a_r8_local_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != MODE_FOLLOW) |=> (ratioOut == $past(localRatio)));
endmodule

// File: rtl/sidechan_rx.sv
`timescale 1ns/1ps
module sidechan_rx
  import sidechan_pkg::*;
#(
  parameter int SUB_BITS = 32,
  parameter int BYTE_W   = 8,
  localparam int SAMPLE_W = SUB_BITS - BYTE_W,
  localparam int RATIO_W  = 2 * BYTE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClk,
  input  logic                frameClk,
  input  logic                serialIn,
  input  logic [1:0]          fmtSel,
  input  logic [2:0]          modeSel,
  input  logic [RATIO_W-1:0]  localRatio,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic [BYTE_W-1:0]   sideByte,
  output logic                byteValid,
  output logic                byteIsRight,
  output logic                framingErr,
  output logic [RATIO_W-1:0]  ratioOut
);
  strobe_t            strb;
  logic               launch;
  logic [RATIO_W-1:0] launchWord;

  sidechan_ctrl #(.SUB_BITS(SUB_BITS)) i_ctrl (
    .bitClk(bitClk), .rstN(rstN), .frameClk(frameClk), .fmtSel(fmtSel), .strb(strb)
  );

  sidechan_dp #(.SUB_BITS(SUB_BITS), .BYTE_W(BYTE_W)) i_dp (
    .bitClk(bitClk), .rstN(rstN), .serialIn(serialIn), .fmtSel(fmtSel), .strb(strb),
    .sampleOut(sampleOut), .sideByte(sideByte), .byteValid(byteValid),
    .byteIsRight(byteIsRight), .framingErr(framingErr),
    .launch(launch), .launchWord(launchWord)
  );

  sidechan_xfer #(.RATIO_W(RATIO_W)) i_xfer (
    .bitClk(bitClk), .clk(clk), .rstN(rstN), .launch(launch), .launchWord(launchWord),
    .modeSel(modeSel), .localRatio(localRatio), .ratioOut(ratioOut)
  );
endmodule

// File: tb/test_sidechan_rx.sv
`timescale 1ns/1ps
module test_sidechan_rx;
  logic        clk = 1'b0, bitClk = 1'b0, rstN = 1'b0;
  logic        frameClk = 1'b0, serialIn = 1'b0;
  logic [1:0]  fmtSel = 2'd0;
  logic [2:0]  modeSel = 3'b100;
  logic [15:0] localRatio = 16'hA5C3;
  logic [23:0] sampleOut;
  logic [7:0]  sideByte;
  logic        byteValid, byteIsRight, framingErr;
  logic [15:0] ratioOut;

  sidechan_rx i_sidechan_rx (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameClk(frameClk), .serialIn(serialIn),
    .fmtSel(fmtSel), .modeSel(modeSel), .localRatio(localRatio),
    .sampleOut(sampleOut), .sideByte(sideByte), .byteValid(byteValid),
    .byteIsRight(byteIsRight), .framingErr(framingErr), .ratioOut(ratioOut)
  );

  always #10 clk = ~clk;       // 50 MHz core clock
  always #55 bitClk = ~bitClk; // unrelated serial bit clock

  int checks = 0, fails = 0;
  bit done = 0;

  // capture of delivered subframes, sampled away from the rising bitClk edge
  logic [7:0]  capByte   [0:63];
  logic [23:0] capSample [0:63];
  logic        capRight  [0:63];
  int capN, errN, dblN;
  logic prevValid;

  always @(negedge bitClk) begin
    if (!rstN) begin
      capN = 0; errN = 0; dblN = 0; prevValid = 1'b0;
    end else begin
      if (byteValid) begin
        if (capN < 64) begin
          capByte[capN] = sideByte; capSample[capN] = sampleOut; capRight[capN] = byteIsRight;
        end
        capN++;
      end
      if (framingErr) errN++;
      if (byteValid && prevValid) dblN++;
      prevValid = byteValid;
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] byteFor(input int seed, input int k);
    return 8'(seed * 53 + k * 29 + 7);
  endfunction

  function automatic logic [23:0] sampleFor(input int seed, input int k);
    return 24'((seed * 41777 + k * 127459) ^ 24'h5A5A5A);
  endfunction

  function automatic logic [31:0] wordFor(input logic [1:0] f, input int seed, input int k);
    return (f == 2'd2) ? {byteFor(seed, k), sampleFor(seed, k)} : {sampleFor(seed, k), byteFor(seed, k)};
  endfunction

  task automatic playBit(input logic d, input logic f);
    @(negedge bitClk);
    serialIn = d;
    frameClk = f;
  endtask

  task automatic doReset(input logic [1:0] f);
    @(negedge bitClk);
    rstN = 1'b0; fmtSel = f; frameClk = 1'b0; serialIn = 1'b0;
    repeat (2) @(negedge bitClk);
    rstN = 1'b1;
    @(negedge bitClk);
    check(byteValid == 1'b0, "R1 byteValid after reset", longint'(byteValid), 0);
    check(framingErr == 1'b0, "R1 framingErr after reset", longint'(framingErr), 0);
    check(ratioOut == localRatio, "R1 ratioOut before any word", longint'(ratioOut), longint'(localRatio));
  endtask

  // LJ-layout subframe of n bits, MSB first
  task automatic sendSub(input logic [31:0] w, input int n, input logic left);
    for (int i = 0; i < n; i++) playBit(w[31-i], left);
  endtask

  task automatic runFormat(input logic [1:0] f, input int nFr, input int seed);
    int slots, e, idx;
    logic fr;
    logic [31:0] w;
    slots = (f == 2'd3) ? 4 : 2;
    doReset(f);
    for (int fi = 0; fi < nFr; fi++) begin
      for (int s = 0; s < slots; s++) begin
        w = (s < 2) ? wordFor(f, seed, 2 * fi + s) : (32'hF0F00F0F ^ 32'(fi * 7 + s));
        for (int i = 0; i < 32; i++) begin
          case (f)
            2'd1:    fr = (i < 31) ? (s == 1) : (s == 0);
            2'd3:    fr = (s == 0) && (i == 0);
            default: fr = (s == 0);
          endcase
          playBit(w[31-i], fr);
        end
      end
    end
    playBit(1'b0, (f == 2'd1) ? 1'b0 : 1'b1);
    for (int i = 0; i < 4; i++) playBit(1'b0, (f == 2'd0 || f == 2'd2) ? 1'b1 : 1'b0);
    e = 2 * nFr;
    // R2 R7: I2S loses the first subframe to alignment; TDM slots 2,3 yield nothing
    check(capN == ((f == 2'd1) ? e - 1 : e), "R2 R7 delivered subframe count", capN, (f == 2'd1) ? e - 1 : e);
    for (int j = 0; j < capN && j < 64; j++) begin
      idx = e - capN + j;
      check(capByte[j] == byteFor(seed, idx), (f == 2'd2) ? "R4 sideByte" : "R3 sideByte",
            longint'(capByte[j]), longint'(byteFor(seed, idx)));
      check(capSample[j] == sampleFor(seed, idx), (f == 2'd2) ? "R4 sampleOut" : "R3 sampleOut",
            longint'(capSample[j]), longint'(sampleFor(seed, idx)));
      check(capRight[j] == 1'(idx % 2), "R2 byteIsRight", longint'(capRight[j]), longint'(idx % 2));
    end
    check(errN == 0, "R6 no framing error on clean stream", errN, 0);
    check(dblN == 0, "R5 byteValid single cycle", dblN, 0);
    repeat (10) @(posedge clk);
    #1;
    check(ratioOut == {byteFor(seed, e - 2), byteFor(seed, e - 1)}, "R8 R10 received ratio",
          longint'(ratioOut), longint'({byteFor(seed, e - 2), byteFor(seed, e - 1)}));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    logic [15:0] rxWord;
    logic [31:0] wa1, wa2, wb1, wb2, wc1, wc2;
    // all four formats, with different data seeds
    for (int f = 0; f < 4; f++) runFormat(2'(f), 6, f + 3);

    // R8 sweep over every mode value after a word is held
    runFormat(2'd0, 3, 11);
    rxWord = {byteFor(11, 4), byteFor(11, 5)};
    for (int m = 0; m < 8; m++) begin
      modeSel = 3'(m);
      localRatio = 16'h1000 + 16'(m * 17);
      repeat (3) @(posedge clk);
      #1;
      check(ratioOut == ((m == 4) ? rxWord : localRatio), "R8 mode select",
            longint'(ratioOut), longint'((m == 4) ? rxWord : localRatio));
    end
    modeSel = 3'b100;

    // R6 R9: truncated left subframe breaks the pair
    wa1 = wordFor(2'd0, 20, 0); wa2 = wordFor(2'd0, 20, 1);
    wb1 = wordFor(2'd0, 20, 2); wb2 = wordFor(2'd0, 20, 3);
    wc1 = wordFor(2'd0, 20, 4); wc2 = wordFor(2'd0, 20, 5);
    doReset(2'd0);
    sendSub(wa1, 32, 1'b1);
    sendSub(wa2, 32, 1'b0);
    sendSub(wb1, 31, 1'b1);
    sendSub(wb2, 32, 1'b0);
    sendSub(wc1, 32, 1'b1);
    repeat (4) @(posedge clk);
    #1;
    check(errN == 1, "R6 one framing error", errN, 1);
    check(capN == 3, "R6 bad subframe not delivered", capN, 3);
    check(capByte[2] == byteFor(20, 3), "R6 byte after error is the right one",
          longint'(capByte[2]), longint'(byteFor(20, 3)));
    check(capRight[2] == 1'b1, "R6 byteIsRight after error", longint'(capRight[2]), 1);
    check(ratioOut == {byteFor(20, 0), byteFor(20, 1)}, "R9 ratio kept after broken pair",
          longint'(ratioOut), longint'({byteFor(20, 0), byteFor(20, 1)}));
    sendSub(wc2, 32, 1'b0);
    for (int i = 0; i < 4; i++) playBit(1'b0, 1'b1);
    repeat (10) @(posedge clk);
    #1;
    check(capN == 5, "R6 deliveries after recovery", capN, 5);
    check(ratioOut == {byteFor(20, 4), byteFor(20, 5)}, "R9 R10 ratio after recovery",
          longint'(ratioOut), longint'({byteFor(20, 4), byteFor(20, 5)}));
    finishRun();
  end

  initial begin
    #3ms;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finishRun();
    end
  end
endmodule